// File: doc/BRIEF.md
# Ethernet Receive Frame Status Generator

This block follows one received Ethernet frame at a time, presented as a byte stream with first-byte, byte-valid and last-byte marks. With the last byte it also receives a count of leftover bits that did not form a whole byte. A separate strobe reports a receive FIFO overrun. While the bytes pass, the block captures the destination address, counts the stored length, and runs a CRC-32 over every byte, including the frame check sequence. At the end of the frame it writes a 16-bit status word and a 16-bit length word, in the form a receive buffer descriptor holds them.

Frames longer than the configured receive buffer size span several buffers. For each buffer that fills up and is followed by more data, the block emits a non-last descriptor that carries only a length. The final descriptor carries the full status. Configuration inputs set promiscuous mode, the station's own unicast address, the maximum legal frame length and the receive buffer size.

Top module: `rx_frame_status`

## Requirements
- R1: The status bit at vector position 7 (broadcast) is 1 in the last descriptor exactly when all six destination-address bytes are 0xFF.
- R2: The status bit at vector position 6 (multicast) is 1 when the first destination byte has its least significant bit set and the address is not broadcast.
- R3: The status bit at vector position 8 (miss) is 1 only when `cfg_promisc` is 1 and the destination matched neither `cfg_station` (first wire byte in bits 47:40) nor broadcast. It is 0 on an address hit, and 0 whenever `cfg_promisc` is 0.
- R4: The status bit at vector position 5 (length violation) is 1 when the stored frame length is greater than `cfg_max_len`.
- R5: Once 2047 bytes have been stored, further bytes are neither counted nor stored, and the status bit at vector position 0 (truncated) is 1. The reported length is then 2047. The CRC still covers every byte.
- R6: The status bit at vector position 4 (non-octet) is 1 when `rx_extra_bits` on the last byte is nonzero and the CRC at the last whole byte fails. When this bit is 1, the CRC-error bit is 0.
- R7: The status bit at vector position 2 (CRC error) is 1 when the frame has no leftover bits and the residue of the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones, expected register value 0xDEBB20E3) is wrong.
- R8: An `rx_overrun` pulse between the first and the last byte of a frame, both included, sets the status bit at vector position 1 (overrun). It forces the miss, length-violation, non-octet and CRC-error bits to 0. An overrun strobe while no frame is in progress has no effect.
- R9: The last descriptor has the status bit at vector position 11 set and a length equal to the stored frame length including the 4 CRC bytes. Bit 3 and all bits not named here are 0.
- R10: Each time a byte arrives after `cfg_buf_size` bytes have filled the current buffer, a non-last descriptor is emitted with an all-zero status and a length equal to `cfg_buf_size`. It comes before any later descriptor.
- R11: The last descriptor's `desc_done` pulse is seen in the second cycle after the cycle of the last byte. When a non-last descriptor falls on the same cycle, the last descriptor follows it one cycle later.
- R12: After reset, `desc_done`, `desc_status` and `desc_len` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_promisc | input | 1 | Promiscuous mode enable |
| cfg_station | input | 48 | Station unicast address, first wire byte in bits 47:40 |
| cfg_max_len | input | 11 | Maximum legal frame length in bytes |
| cfg_buf_size | input | 11 | Receive buffer size in bytes, at least 1 |
| rx_valid | input | 1 | A received byte is present |
| rx_first | input | 1 | The present byte is the first of the frame |
| rx_last | input | 1 | The present byte is the last of the frame |
| rx_data | input | 8 | Received byte, least significant bit first on the wire |
| rx_extra_bits | input | 3 | Leftover bit count after the last whole byte, valid with rx_last |
| rx_overrun | input | 1 | Receive FIFO overrun strobe |
| desc_done | output | 1 | One-cycle pulse: a descriptor word pair is valid |
| desc_status | output | 16 | Descriptor status word |
| desc_len | output | 16 | Descriptor data length word |

## Verification
Two outputs can become due in the same cycle: a buffer can close on the very byte that ends the frame. The bench provokes this with a 49-byte frame and a 16-byte buffer, and follows that frame at once with another frame. It judges the order and the cycle spacing of the non-last and last descriptors against a queue of expected words. It also drives the overrun strobe on the last byte, where overrun capture and frame completion coincide, and checks that the error bits are masked in that descriptor.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   // Status vector positions (vector bit 15 is the most significant bit)
   localparam int unsigned SB_TRUNC = 0;
   localparam int unsigned SB_OVR   = 1;
   localparam int unsigned SB_CRC   = 2;
   localparam int unsigned SB_ODD   = 4;
   localparam int unsigned SB_LONG  = 5;
   localparam int unsigned SB_MCAST = 6;
   localparam int unsigned SB_BCAST = 7;
   localparam int unsigned SB_MISS  = 8;
   localparam int unsigned SB_LAST  = 11;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
   localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;
   localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

   function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction
endpackage

// File: rtl/rxs_addr_class.sv
module rxs_addr_class #(
   parameter int ADDR_BYTES = 6,
   parameter int IDX_W      = 11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic [IDX_W-1:0]        idx,
   input  logic [7:0]              data,
   input  logic [8*ADDR_BYTES-1:0] station,
   output logic                    is_bcast,
   output logic                    is_mcast,
   output logic                    hit
);
   localparam int AW = 8 * ADDR_BYTES;

   logic [AW-1:0] da_flat;

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_da
      logic [7:0] b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            b_q <= '0;
         else if (take && idx == IDX_W'(g))     b_q <= data;
      end
      assign da_flat[AW-1-8*g -: 8] = b_q;
   end

   assign is_bcast = &da_flat;
   assign is_mcast = da_flat[AW-8] & ~is_bcast;
   assign hit      = (da_flat == station) | is_bcast;
endmodule

// File: rtl/rxs_len_ctr.sv
module rxs_len_ctr #(
   parameter int MAX_STORE = 2047,
   parameter int CNT_W     = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             first,
   input  logic [CNT_W-1:0] buf_size,
   output logic [CNT_W-1:0] frame_cnt,
   output logic             trunc,
   output logic             nl_evt
);
   logic [CNT_W-1:0] desc_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_cnt <= '0;
         desc_cnt  <= '0;
         trunc     <= 1'b0;
         nl_evt    <= 1'b0;
      end else begin
         nl_evt <= 1'b0;
         if (take) begin
            if (first) begin
               frame_cnt <= CNT_W'(1);
               desc_cnt  <= CNT_W'(1);
               trunc     <= 1'b0;
            end else if (frame_cnt == CNT_W'(MAX_STORE)) begin
               trunc <= 1'b1;
            end else begin
               frame_cnt <= frame_cnt + 1'b1;
               if (desc_cnt == buf_size) begin
                  desc_cnt <= CNT_W'(1);
                  nl_evt   <= 1'b1;
               end else begin
                  desc_cnt <= desc_cnt + 1'b1;
               end
            end
         end
      end
   end

   p_trunc_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trunc |-> frame_cnt == CNT_W'(MAX_STORE));
   p_trunc_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !first && trunc) |=> $stable(frame_cnt));
   p_new_buffer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      nl_evt |-> desc_cnt == CNT_W'(1));
endmodule

// File: rtl/rxs_crc.sv
module rxs_crc (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       first,
   input  logic [7:0] data,
   output logic       fcs_ok
);
   import rxs_pkg::*;

   logic [31:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= CRC_PRESET;
      else if (take)   crc_q <= crc_byte(first ? CRC_PRESET : crc_q, data);
   end

   assign fcs_ok = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status #(
   parameter int ADDR_BYTES = 6,
   parameter int MAX_STORE  = 2047,
   parameter int OUT_W      = 16,
   parameter int CNT_W      = $clog2(MAX_STORE + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_promisc,
   input  logic [8*ADDR_BYTES-1:0] cfg_station,
   input  logic [CNT_W-1:0]        cfg_max_len,
   input  logic [CNT_W-1:0]        cfg_buf_size,
   input  logic                    rx_valid,
   input  logic                    rx_first,
   input  logic                    rx_last,
   input  logic [7:0]              rx_data,
   input  logic [2:0]              rx_extra_bits,
   input  logic                    rx_overrun,
   output logic                    desc_done,
   output logic [OUT_W-1:0]        desc_status,
   output logic [OUT_W-1:0]        desc_len
);
   import rxs_pkg::*;

   if (MAX_STORE >= 2**OUT_W) begin : g_bad_len
      $error("MAX_STORE does not fit the length word");
   end
   if (OUT_W < 12) begin : g_bad_w
      $error("OUT_W too narrow for the status layout");
   end
   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("ADDR_BYTES must be at least 1");
   end

   logic             first_b;
   logic [CNT_W-1:0] frame_cnt;
   logic             trunc, nl_evt, fcs_ok;
   logic             is_bcast, is_mcast, hit;
   logic             in_frame, ovr_q, fin_q;
   logic [2:0]       extra_q;
   logic             hold_q;
   logic [OUT_W-1:0] hold_st, hold_len, last_st;

   assign first_b = rx_valid & rx_first;

   rxs_addr_class #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(CNT_W)) i_addr (
      .clk(clk), .rst_n(rst_n), .take(rx_valid),
      .idx(rx_first ? '0 : frame_cnt), .data(rx_data), .station(cfg_station),
      .is_bcast(is_bcast), .is_mcast(is_mcast), .hit(hit));

   rxs_len_ctr #(.MAX_STORE(MAX_STORE), .CNT_W(CNT_W)) i_len (
      .clk(clk), .rst_n(rst_n), .take(rx_valid), .first(rx_first),
      .buf_size(cfg_buf_size), .frame_cnt(frame_cnt), .trunc(trunc), .nl_evt(nl_evt));

   rxs_crc i_crc (
      .clk(clk), .rst_n(rst_n), .take(rx_valid), .first(rx_first),
      .data(rx_data), .fcs_ok(fcs_ok));

   // Frame tracking, overrun capture and end-of-frame registration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         ovr_q    <= 1'b0;
         fin_q    <= 1'b0;
         extra_q  <= '0;
      end else begin
         fin_q <= rx_valid & rx_last;
         if (rx_valid && rx_last)  extra_q <= rx_extra_bits;
         if (first_b)              ovr_q <= rx_overrun;
         else if (in_frame && rx_overrun) ovr_q <= 1'b1;
         if (rx_valid && rx_last)  in_frame <= 1'b0;
         else if (first_b)         in_frame <= 1'b1;
      end
   end

   // Last-descriptor status word
   always_comb begin
      logic crc_bad, odd;
      crc_bad = ~fcs_ok;
      odd     = (extra_q != 3'd0);
      last_st = '0;
      last_st[SB_LAST]  = 1'b1;
      last_st[SB_TRUNC] = trunc;
      last_st[SB_BCAST] = is_bcast;
      last_st[SB_MCAST] = is_mcast;
      if (ovr_q) begin
         last_st[SB_OVR] = 1'b1;
      end else begin
         last_st[SB_MISS] = cfg_promisc & ~hit;
         last_st[SB_LONG] = (frame_cnt > cfg_max_len);
         last_st[SB_ODD]  = odd & crc_bad;
         last_st[SB_CRC]  = ~odd & crc_bad;
      end
   end

   // Output stage: non-last first, then a held last descriptor, then a fresh one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_done   <= 1'b0;
         desc_status <= '0;
         desc_len    <= '0;
         hold_q      <= 1'b0;
         hold_st     <= '0;
         hold_len    <= '0;
      end else begin
         desc_done <= 1'b0;
         if (nl_evt) begin
            desc_done   <= 1'b1;
            desc_status <= '0;
            desc_len    <= OUT_W'(cfg_buf_size);
         end else if (hold_q) begin
            desc_done   <= 1'b1;
            desc_status <= hold_st;
            desc_len    <= hold_len;
         end else if (fin_q) begin
            desc_done   <= 1'b1;
            desc_status <= last_st;
            desc_len    <= OUT_W'(frame_cnt);
         end
         if (fin_q && (nl_evt || hold_q)) begin
            hold_q   <= 1'b1;
            hold_st  <= last_st;
            hold_len <= OUT_W'(frame_cnt);
         end else if (hold_q && !nl_evt) begin
            hold_q <= 1'b0;
         end
      end
   end

   p_ovr_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_done && desc_status[SB_OVR]) |->
         !(desc_status[SB_MISS] || desc_status[SB_LONG] || desc_status[SB_ODD] || desc_status[SB_CRC]));
   p_odd_hides_crc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      desc_done |-> !(desc_status[SB_ODD] && desc_status[SB_CRC]));
   p_bc_mc_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      desc_done |-> !(desc_status[SB_BCAST] && desc_status[SB_MCAST]));
   p_nonlast_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_done && !desc_status[SB_LAST]) |->
         (desc_status == '0 && desc_len == OUT_W'(cfg_buf_size)));
   p_hold_no_loss_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(fin_q && nl_evt && hold_q));
   p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      desc_done |-> desc_len <= OUT_W'(MAX_STORE));
endmodule

// File: tb/test_rx_frame_status.sv
module test_rx_frame_status;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_promisc = 1'b0;
   logic [47:0] cfg_station = 48'h02_11_22_33_44_55;
   logic [10:0] cfg_max_len = 11'd1518;
   logic [10:0] cfg_buf_size = 11'd2047;
   logic        rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0, rx_overrun = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [2:0]  rx_extra_bits = '0;
   logic        desc_done;
   logic [15:0] desc_status, desc_len;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   int eof_cyc  = 0;

   logic [15:0] q_st[$];
   logic [15:0] q_len[$];
   int          q_dly[$];
   string       q_tag[$];

   rx_frame_status i_rx_frame_status (
      .clk(clk), .rst_n(rst_n), .cfg_promisc(cfg_promisc), .cfg_station(cfg_station),
      .cfg_max_len(cfg_max_len), .cfg_buf_size(cfg_buf_size), .rx_valid(rx_valid),
      .rx_first(rx_first), .rx_last(rx_last), .rx_data(rx_data),
      .rx_extra_bits(rx_extra_bits), .rx_overrun(rx_overrun), .desc_done(desc_done),
      .desc_status(desc_status), .desc_len(desc_len));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int b = 0; b < 8; b++) begin
         logic fb;
         fb = r[0] ^ d[b];
         r  = {1'b0, r[31:1]};
         if (fb) r = r ^ 32'hEDB88320;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard whenever a descriptor appears
   always @(negedge clk) begin
      if (rst_n && desc_done) begin
         if (q_st.size() == 0) begin
            check("R10 unexpected descriptor", {desc_status, desc_len}, 32'h0);
         end else begin
            logic [15:0] es, el;
            int ed;
            string tg;
            es = q_st.pop_front(); el = q_len.pop_front();
            ed = q_dly.pop_front(); tg = q_tag.pop_front();
            check({tg, " status"}, {16'h0, desc_status}, {16'h0, es});
            check({tg, " length"}, {16'h0, desc_len}, {16'h0, el});
            if (ed >= 0) check({tg, " R11 delay"}, cyc - eof_cyc, ed);
         end
      end
   end

   // Driver: builds a frame, pushes expected descriptors, then drives it
   task automatic send(input int n, input logic [47:0] da, input bit bad_fcs,
                       input int extra, input int ovr_idx, input string tag, input bit gap);
      logic [7:0] fr[$];
      logic [31:0] c, fcs;
      int stored, nnl;
      logic [15:0] st;
      bit bc, mc, hit;
      for (int i = 0; i < 6; i++) fr.push_back(da[47-8*i -: 8]);
      for (int i = 6; i < n - 4; i++) fr.push_back(8'((i * 7 + 3) & 255));
      c = 32'hFFFFFFFF;
      foreach (fr[i]) c = ref_crc(c, fr[i]);
      fcs = ~c;
      if (bad_fcs) fcs[0] = ~fcs[0];
      for (int i = 0; i < 4; i++) fr.push_back(fcs[8*i +: 8]);

      stored = (n > 2047) ? 2047 : n;
      nnl = (stored - 1) / int'(cfg_buf_size);
      for (int i = 0; i < nnl; i++) begin
         q_st.push_back(16'h0); q_len.push_back(16'(cfg_buf_size));
         q_dly.push_back(-1); q_tag.push_back({tag, " R10 non-last"});
      end
      bc  = (da == 48'hFFFF_FFFF_FFFF);
      mc  = da[40] && !bc;
      hit = (da == cfg_station) || bc;
      st  = 16'h0800;                       // R9 last bit
      if (bc) st |= 16'h0080;               // R1
      if (mc) st |= 16'h0040;               // R2
      if (n > 2047) st |= 16'h0001;         // R5
      if (ovr_idx >= 0) st |= 16'h0002;     // R8
      else begin
         if (cfg_promisc && !hit) st |= 16'h0100;            // R3
         if (stored > int'(cfg_max_len)) st |= 16'h0020;     // R4
         if (extra != 0 && bad_fcs) st |= 16'h0010;          // R6
         if (extra == 0 && bad_fcs) st |= 16'h0004;          // R7
      end
      q_st.push_back(st); q_len.push_back(16'(stored));
      q_dly.push_back((nnl > 0 && (stored - 1) % int'(cfg_buf_size) == 0) ? 3 : 2);
      q_tag.push_back(tag);

      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = fr[i];
         rx_first = (i == 0); rx_last = (i == n - 1);
         rx_extra_bits = (i == n - 1) ? 3'(extra) : 3'd0;
         rx_overrun = (i == ovr_idx);
         if (i == n - 1) eof_cyc = cyc;
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0; rx_overrun = 1'b0;
      rx_extra_bits = '0;
      if (gap) repeat (4) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fails++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;
   localparam logic [47:0] OTHER = 48'h02_99_88_77_66_55;

   initial begin
      repeat (3) @(negedge clk);
      check("R12 reset done",   {31'h0, desc_done}, 32'h0);
      check("R12 reset status", {16'h0, desc_status}, 32'h0);
      check("R12 reset length", {16'h0, desc_len}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      send(64, cfg_station, 0, 0, -1, "R9 unicast hit", 1);
      cfg_promisc = 1'b1;
      send(64, BCAST, 0, 0, -1, "R1 broadcast", 1);
      send(70, MCAST, 0, 0, -1, "R2 R3 multicast miss", 1);
      send(66, OTHER, 0, 0, -1, "R3 promisc miss", 1);
      send(66, cfg_station, 0, 0, -1, "R3 promisc hit", 1);
      cfg_promisc = 1'b0;
      send(66, OTHER, 0, 0, -1, "R3 no promisc", 1);
      send(72, cfg_station, 1, 0, -1, "R7 crc error", 1);
      send(72, cfg_station, 1, 3, -1, "R6 odd with bad crc", 1);
      send(72, cfg_station, 0, 5, -1, "R6 odd with good crc", 1);
      cfg_max_len = 11'd100;
      send(120, cfg_station, 0, 0, -1, "R4 too long", 1);
      send(100, cfg_station, 0, 0, -1, "R4 at limit", 1);
      cfg_max_len = 11'd50; cfg_promisc = 1'b1;
      send(80, MCAST, 1, 2, 30, "R8 overrun masks", 1);
      cfg_max_len = 11'd1518; cfg_promisc = 1'b0;
      send(64, cfg_station, 1, 0, 63, "R8 overrun on last byte", 1);
      @(negedge clk); rx_overrun = 1'b1;
      repeat (3) @(negedge clk); rx_overrun = 1'b0;
      send(64, cfg_station, 0, 0, -1, "R8 idle overrun ignored", 1);
      cfg_buf_size = 11'd16;
      send(40, cfg_station, 0, 0, -1, "R10 two buffers", 1);
      send(49, cfg_station, 0, 0, -1, "R10 R11 close on last byte", 0);
      send(12, cfg_station, 0, 0, -1, "R11 back to back", 1);
      cfg_buf_size = 11'd2047; cfg_max_len = 11'd2047;
      send(2050, cfg_station, 0, 0, -1, "R5 truncated", 1);
      send(2048, cfg_station, 0, 0, -1, "R5 one past limit", 1);
      cfg_max_len = 11'd2000;
      send(2047, cfg_station, 0, 0, -1, "R4 R5 full not truncated", 1);

      repeat (10) @(negedge clk);
      check("R10 scoreboard drained", q_st.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule